// File: doc/BRIEF.md
# Memory-to-Memory DMA Channel with Separate Buffer and Control State Machines

This block is a single DMA channel that copies data either from memory to memory or between memory and a handshaking peripheral. Software loads two ping-pong slots, each with a source address, a destination address and a byte count. Each slot is a unit of work. While the channel works through one slot, software can refill the other one.

Two state machines drive the channel, and both can be read in the status word:
- The **control machine** steps each beat through a read phase, a write phase and an optional bandwidth wait. It sits in stall whenever it has nothing it may move.
- The **buffer machine** reports how many slots are loaded.

A channel is fully drained only when the buffer machine reads empty and the control machine reads stall. The done flag alone does not mean this.

Each beat reads one word of the programmed peripheral width and writes the same data back out. Pure memory copies run only after a software start trigger. Handshaked transfers are paced by a peripheral request line, unless the handshake is switched off.

Top module: `m2m_dma_chan`

## Requirements
- R1: After reset every register reads zero, the control machine is idle (status[3:1]=0), the buffer machine is empty (status[5:4]=0), mem_req is low and irq is low.
- R2: Writing a nonzero byte count to slot 0 (offset 0x10) or slot 1 (offset 0x14) loads that slot, and writing zero unloads it. Status bits [5:4] read 0 when no slot is loaded, 1 when one slot is loaded and 2 when both are loaded.
- R3: With enable (control bit 3) set and no slot loaded, the control machine reads stall (1) and issues no request. Clearing enable drops mem_req in the cycle the new control value takes effect, and the control machine reads idle (0) one cycle later.
- R4: In copy mode (control bits [14:13]=0), beats begin only after a control write that sets start (bit 4) and enable while enable was already set. Start written in the same write that first sets enable has no effect.
- R5: A beat reads at the slot's source address (mem_wr=0, status[3:1]=2) until mem_ack. It then writes the captured word at the destination address (mem_wr=1, status[3:1]=3) until mem_ack. The request and its address stay steady until acknowledged.
- R6: Control bits [10:9] select the beat width: 0 is 1 byte, 1 is 2 bytes, 2 or 3 is 4 bytes. After each write, every non-held address advances by the width and the count drops by the width, floored at zero.
- R7: Control bit 11 keeps the destination address fixed and bit 12 keeps the source address fixed.
- R8: When a slot's count reaches zero, these things happen together:
  - the slot unloads;
  - the free-buffer flag (interrupt register bit 1) sets;
  - the channel moves to the other slot if that slot is loaded.
  If the other slot is not loaded, done also sets (status bit 6, interrupt register bit 2), the control machine stalls, and copy mode needs a new start.
- R9: In a handshaked mode (bits [14:13] nonzero) with bit 24 clear, each beat waits for periph_req high. With bit 24 set, beats run freely and need no start.
- R10: A nonzero wait count in control bits [31:25] holds the control machine in bandwidth wait (status[3:1]=4) for that many cycles after every write.
- R11: irq is high when done is set and bit 2 is set, or when the free-buffer flag is set and bit 21 is set. Writing the interrupt register (0x04) clears each flag whose bit is written as 0.
- R12: Offsets 0x10/0x14 return the live counts, 0x18/0x1C the live source addresses and 0x2C/0x30 the live destination addresses. Offset 0x00 returns every control bit as written, including the request-source field [23:22], except that start reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write byte offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 6 | Register read byte offset |
| rd_data | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_wr | output | 1 | 1 for write phase, 0 for read phase |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | DW | Write data |
| mem_size | output | 2 | Beat size code: 0 byte, 1 half, 2 word |
| mem_rdata | input | DW | Read data, valid with mem_ack |
| mem_ack | input | 1 | Completes the current phase |
| periph_req | input | 1 | Peripheral request for handshaked modes |
| irq | output | 1 | Interrupt |

## Verification
The bench aims at several corner cases. Each is listed with what a broken design would do.

- **Start in the enabling write.** A design that armed start in the same write that sets enable would begin copying too early.
- **Ping-pong hand-over.** A wrong hand-over would stall between slots or repeat a slot.
- **Count flooring.** A 16-bit beat on an odd count must floor at zero. A design that wrapped instead would never finish.
- **Start disarm after done.** After done, a reloaded slot must wait for a new start. A design that kept start armed would run away on the refill.
- **Handshake gating.** With periph_req low, a handshaked channel must issue no request.
- **Abort.** Clearing enable in the middle of a beat must drop the request at once.
- **Bandwidth wait.** The bench counts the wait cycles. A miscounted wait shows up as a wrong total.

// File: rtl/m2m_dma_chan.sv
module m2m_dma_chan #(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int CW  = 16,
  parameter int WSW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [5:0]    wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [5:0]    rd_addr,
  output logic [31:0]   rd_data,
  output logic          mem_req,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [1:0]    mem_size,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack,
  input  logic          periph_req,
  output logic          irq
);
  localparam logic [2:0] S_IDLE = 3'd0, S_STALL = 3'd1, S_RD = 3'd2, S_WR = 3'd3, S_BWC = 3'd4;

  logic [31:0]    ctrl_q;
  logic [2:0]     ctl;
  logic [1:0]     v;
  logic           cur, go, done_f, nfb_f;
  logic [AW-1:0]  sar [2];
  logic [AW-1:0]  dar [2];
  logic [CW-1:0]  bcr [2];
  logic [DW-1:0]  data_q;
  logic [WSW-1:0] wcnt;

  wire           en    = ctrl_q[3];
  wire [1:0]     pw    = ctrl_q[10:9];
  wire [1:0]     mode  = ctrl_q[14:13];
  wire [WSW-1:0] ws    = ctrl_q[25 +: WSW];
  wire           sel   = v[cur] ? cur : ~cur;
  wire           gate  = (mode == 2'd0) ? go : (ctrl_q[24] | periph_req);
  wire [CW-1:0]  inc   = (pw == 2'd0) ? CW'(1) : (pw == 2'd1) ? CW'(2) : CW'(4);
  wire [CW-1:0]  left  = (bcr[cur] > inc) ? bcr[cur] - inc : '0;
  wire [1:0]     level = (v == 2'b00) ? 2'd0 : (v == 2'b11) ? 2'd2 : 2'd1;

  assign mem_req   = en && (ctl == S_RD || ctl == S_WR);
  assign mem_wr    = (ctl == S_WR);
  assign mem_addr  = (ctl == S_WR) ? dar[cur] : sar[cur];
  assign mem_wdata = data_q;
  assign mem_size  = pw[1] ? 2'd2 : pw;
  assign irq       = (done_f && ctrl_q[2]) || (nfb_f && ctrl_q[21]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0; ctl <= S_IDLE; v <= '0; cur <= 1'b0; go <= 1'b0;
      done_f <= 1'b0; nfb_f <= 1'b0; data_q <= '0; wcnt <= '0;
      for (int i = 0; i < 2; i++) begin
        sar[i] <= '0; dar[i] <= '0; bcr[i] <= '0;
      end
    end else begin
      if (!en) ctl <= S_IDLE;
      else case (ctl)
        S_IDLE, S_STALL:
          if (v != 2'b00 && gate) begin cur <= sel; ctl <= S_RD; end
          else ctl <= S_STALL;
        S_RD:
          if (mem_ack) begin data_q <= mem_rdata; ctl <= S_WR; end
        S_WR:
          if (mem_ack) begin
            if (!ctrl_q[12]) sar[cur] <= sar[cur] + AW'(inc);
            if (!ctrl_q[11]) dar[cur] <= dar[cur] + AW'(inc);
            bcr[cur] <= left;
            if (left == '0) begin
              v[cur] <= 1'b0;
              nfb_f  <= 1'b1;
              if (v[~cur]) cur <= ~cur;
              else begin done_f <= 1'b1; go <= 1'b0; end
            end
            if (ws != '0) begin wcnt <= ws; ctl <= S_BWC; end
            else ctl <= S_STALL;
          end
        S_BWC:
          if (wcnt <= WSW'(1)) ctl <= S_STALL;
          else wcnt <= wcnt - WSW'(1);
        default: ctl <= S_IDLE;
      endcase

      if (wr_en) begin
        case (wr_addr)
          6'h00: begin
            ctrl_q <= wr_data & ~32'h10;
            if (wr_data[4] && wr_data[3] && en) go <= 1'b1;
            if (!wr_data[3]) go <= 1'b0;
          end
          6'h04: begin
            if (!wr_data[2]) done_f <= 1'b0;
            if (!wr_data[1]) nfb_f  <= 1'b0;
          end
          6'h10: begin bcr[0] <= wr_data[CW-1:0]; v[0] <= |wr_data[CW-1:0]; end
          6'h14: begin bcr[1] <= wr_data[CW-1:0]; v[1] <= |wr_data[CW-1:0]; end
          6'h18: sar[0] <= wr_data[AW-1:0];
          6'h1C: sar[1] <= wr_data[AW-1:0];
          6'h2C: dar[0] <= wr_data[AW-1:0];
          6'h30: dar[1] <= wr_data[AW-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_addr)
      6'h00:   rd_data = ctrl_q;
      6'h04:   rd_data = {29'd0, done_f, nfb_f, 1'b0};
      6'h0C:   rd_data = {25'd0, done_f, level, ctl, 1'b0};
      6'h10:   rd_data = 32'(bcr[0]);
      6'h14:   rd_data = 32'(bcr[1]);
      6'h18:   rd_data = 32'(sar[0]);
      6'h1C:   rd_data = 32'(sar[1]);
      6'h2C:   rd_data = 32'(dar[0]);
      6'h30:   rd_data = 32'(dar[1]);
      default: rd_data = '0;
    endcase
  end

  AST_OFF_GOES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ctl == S_IDLE); // R3
  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_wr && mem_ack && !wr_en) |=> (mem_req && mem_wr)); // R5
  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !wr_en) |=> (mem_req && $stable(mem_addr) && $stable(mem_wr))); // R5
  AST_WDATA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && $past(mem_wr)) |-> $stable(mem_wdata)); // R5
  AST_DONE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done_f) && !$past(wr_en)) |-> (v == 2'b00)); // R8
endmodule

// File: tb/tb_m2m_dma_chan.sv
module tb_m2m_dma_chan;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, mem_ack = 1'b0, periph_req = 1'b0;
  logic [5:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, mem_rdata = '0, rd_data, mem_addr, mem_wdata;
  logic mem_req, mem_wr, irq;
  logic [1:0] mem_size;

  m2m_dma_chan dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .mem_req(mem_req), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_size(mem_size), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .periph_req(periph_req), .irq(irq));

  always #4 clk = ~clk;

  int vectors = 0, fails = 0, cycles = 0, bwc_seen = 0;
  string tag = "R1";
  logic [31:0] mem [logic [31:0]];

  function automatic logic [31:0] pat(logic [31:0] a);
    return a * 32'd3 + 32'h1111_0000;
  endfunction

  // behavioural reference state
  logic [31:0] mctrl, msar [2], mdar [2], mdata;
  int mst, mbcr [2], mwcnt;
  bit [1:0] mv;
  bit mcur, mgo, mdone, mnfb;
  bit men, mgate, c;
  int pw, inc, ws, left;

  always @(posedge clk) begin
    if (!rst_n) begin
      mctrl = 0; mst = 0; mv = 0; mcur = 0; mgo = 0; mdone = 0; mnfb = 0; mdata = 0; mwcnt = 0;
      for (int i = 0; i < 2; i++) begin msar[i] = 0; mdar[i] = 0; mbcr[i] = 0; end
    end else begin
      men = mctrl[3]; pw = int'(mctrl[10:9]);
      inc = (pw == 0) ? 1 : (pw == 1) ? 2 : 4;
      ws = int'(mctrl[31:25]);
      mgate = (mctrl[14:13] == 0) ? mgo : (mctrl[24] || periph_req);
      c = mcur;
      if (!men) mst = 0;
      else if (mst <= 1) begin
        if (mv != 0 && mgate) begin mcur = mv[c] ? c : !c; mst = 2; end else mst = 1;
      end else if (mst == 2) begin
        if (mem_ack) begin mdata = mem_rdata; mst = 3; end
      end else if (mst == 3) begin
        if (mem_ack) begin
          left = (mbcr[c] > inc) ? mbcr[c] - inc : 0;
          if (!mctrl[12]) msar[c] = msar[c] + inc;
          if (!mctrl[11]) mdar[c] = mdar[c] + inc;
          mbcr[c] = left;
          if (left == 0) begin
            mv[c] = 0; mnfb = 1;
            if (mv[!c]) mcur = !c; else begin mdone = 1; mgo = 0; end
          end
          if (ws != 0) begin mwcnt = ws; mst = 4; end else mst = 1;
        end
      end else begin
        if (mwcnt <= 1) mst = 1; else mwcnt--;
      end
      if (wr_en) case (wr_addr)
        6'h00: begin
          if (wr_data[4] && wr_data[3] && men) mgo = 1;
          if (!wr_data[3]) mgo = 0;
          mctrl = wr_data & ~32'h10;
        end
        6'h04: begin if (!wr_data[2]) mdone = 0; if (!wr_data[1]) mnfb = 0; end
        6'h10: begin mbcr[0] = int'(wr_data[15:0]); mv[0] = (wr_data[15:0] != 0); end
        6'h14: begin mbcr[1] = int'(wr_data[15:0]); mv[1] = (wr_data[15:0] != 0); end
        6'h18: msar[0] = wr_data; 6'h1C: msar[1] = wr_data;
        6'h2C: mdar[0] = wr_data; 6'h30: mdar[1] = wr_data;
        default: ;
      endcase
    end
  end

  function automatic logic [31:0] exp_rd(logic [5:0] a);
    logic [1:0] lvl;
    lvl = (mv == 0) ? 2'd0 : (mv == 2'b11) ? 2'd2 : 2'd1;
    case (a)
      6'h00: return mctrl;
      6'h04: return {29'd0, mdone, mnfb, 1'b0};
      6'h0C: return {25'd0, mdone, lvl, 3'(mst), 1'b0};
      6'h10: return 32'(mbcr[0]); 6'h14: return 32'(mbcr[1]);
      6'h18: return msar[0]; 6'h1C: return msar[1];
      6'h2C: return mdar[0]; 6'h30: return mdar[1];
      default: return 32'd0;
    endcase
  endfunction

  // per-cycle comparison, well after the edge
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      logic e_req, e_wr, e_irq;
      logic [31:0] e_addr, e_rd;
      e_req = mctrl[3] && (mst == 2 || mst == 3);
      e_wr = (mst == 3);
      e_addr = e_wr ? mdar[mcur] : msar[mcur];
      e_irq = (mdone && mctrl[2]) || (mnfb && mctrl[21]);
      e_rd = exp_rd(rd_addr);
      vectors++;
      if (mem_req !== e_req || irq !== e_irq || rd_data !== e_rd ||
          (e_req && (mem_wr !== e_wr || mem_addr !== e_addr)) ||
          (e_req && e_wr && mem_wdata !== mdata)) begin
        fails++;
        $display("FAIL %s cycle %0d: req/wr/addr/wdata/irq/rd act %b/%b/%h/%h/%b/%h exp %b/%b/%h/%h/%b/%h",
          tag, cycles, mem_req, mem_wr, mem_addr, mem_wdata, irq, rd_data,
          e_req, e_wr, e_addr, mdata, e_irq, e_rd);
      end
      if (rd_addr == 6'h0C && rd_data[3:1] == 3'd4) bwc_seen++;
    end
  end

  // memory responder
  always @(negedge clk) begin
    if (!rst_n) mem_ack = 1'b0;
    else if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      mem_ack = 1'b1;
      if (mem_wr) mem[mem_addr] = mem_wdata;
      else mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : pat(mem_addr);
    end
  end

  task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act %h exp %h", t, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk); rd_addr = a; #1 d = rd_data; rd_addr = 6'h0C;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (rd_data[6]) break;
    end
    repeat (12) @(negedge clk);
  endtask

  task automatic idle_cycles(int n, string t);
    for (int i = 0; i < n; i++) begin @(negedge clk); chk(t, {31'd0, mem_req}, 32'd0); end
  endtask

  localparam logic [31:0] EN = 32'h8, GO = 32'h18, W32 = 32'h400, W16 = 32'h200;

  initial begin
    logic [31:0] d;
    rd_addr = 6'h0C;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tag = "R1";
    chk("R1 status", rd_data, 32'd0); chk("R1 req", {31'd0, mem_req}, 0); chk("R1 irq", {31'd0, irq}, 0);
    rd(6'h00, d); chk("R1 ctrl", d, 0);

    tag = "R2";
    wr(6'h10, 8);  chk("R2 one slot", rd_data, 32'h10);
    wr(6'h14, 4);  chk("R2 two slots", rd_data, 32'h20);
    wr(6'h14, 0);  chk("R2 unload", rd_data, 32'h10);
    wr(6'h10, 0);  chk("R2 empty", rd_data, 32'h00);

    tag = "R3";
    wr(6'h00, EN); @(negedge clk); chk("R3 stall empty", rd_data, 32'h2);
    idle_cycles(5, "R3 no req");
    wr(6'h00, 0); @(negedge clk); chk("R3 idle", rd_data, 32'h0);

    tag = "R4";
    wr(6'h18, 32'h1000); wr(6'h2C, 32'h2000); wr(6'h10, 8);
    wr(6'h00, W32 | 32'h4 | GO);
    idle_cycles(10, "R4 start with enable ignored");
    tag = "R5";
    wr(6'h00, W32 | 32'h4 | GO);
    wait_done();
    chk("R5 copy w0", mem[32'h2000], pat(32'h1000));
    chk("R5 copy w1", mem[32'h2004], pat(32'h1004));
    chk("R11 done irq", {31'd0, irq}, 1);
    tag = "R12";
    rd(6'h18, d); chk("R12 src live", d, 32'h1008);
    rd(6'h2C, d); chk("R12 dst live", d, 32'h2008);
    rd(6'h10, d); chk("R12 count live", d, 0);
    tag = "R11";
    wr(6'h04, 0); chk("R11 irq cleared", {31'd0, irq}, 0);
    wr(6'h00, 0);

    tag = "R6";
    wr(6'h18, 32'h1100); wr(6'h2C, 32'h2100); wr(6'h10, 3);
    wr(6'h00, EN); wr(6'h00, GO);
    wait_done();
    for (int k = 0; k < 3; k++) chk("R6 byte copy", mem[32'h2100 + k], pat(32'h1100 + k));
    wr(6'h04, 0); wr(6'h00, 0);

    tag = "R7";
    wr(6'h1C, 32'h3000); wr(6'h30, 32'h4000); wr(6'h14, 3);
    wr(6'h00, EN | W16 | 32'h1000); wr(6'h00, GO | W16 | 32'h1000);
    wait_done();
    rd(6'h1C, d); chk("R7 src held", d, 32'h3000);
    rd(6'h30, d); chk("R6 dst step 2x2", d, 32'h4004);
    chk("R7 held data", mem[32'h4002], pat(32'h3000));
    wr(6'h04, 0);
    wr(6'h1C, 32'h3100); wr(6'h30, 32'h4100); wr(6'h14, 8);
    wr(6'h00, EN | W32 | 32'h800); wr(6'h00, GO | W32 | 32'h800);
    wait_done();
    rd(6'h30, d); chk("R7 dst held", d, 32'h4100);
    chk("R7 last word kept", mem[32'h4100], pat(32'h3104));
    wr(6'h04, 0); wr(6'h00, 0);

    tag = "R8";
    wr(6'h18, 32'h5000); wr(6'h2C, 32'h6000); wr(6'h10, 8);
    wr(6'h1C, 32'h5100); wr(6'h30, 32'h6100); wr(6'h14, 4);
    wr(6'h00, EN | W32 | 32'h20_0000); wr(6'h00, GO | W32 | 32'h20_0000);
    wait_done();
    chk("R8 slot1 copied", mem[32'h6100], pat(32'h5100));
    chk("R8 finished status", rd_data, 32'h42);
    rd(6'h04, d); chk("R8 flags", d, 32'h6);
    chk("R11 nfb irq", {31'd0, irq}, 1);
    wr(6'h10, 4);
    idle_cycles(8, "R8 start disarmed");
    chk("R8 refill waits", rd_data, 32'h52);
    tag = "R11";
    wr(6'h04, 32'h4); chk("R11 nfb only cleared", {31'd0, irq}, 0);
    rd(6'h04, d); chk("R11 done kept", d, 32'h4);
    wr(6'h04, 0); wr(6'h10, 0); wr(6'h00, 0);

    tag = "R9";
    wr(6'h18, 32'h7000); wr(6'h2C, 32'h7800); wr(6'h10, 8);
    wr(6'h00, EN | W32 | 32'h2000);
    idle_cycles(10, "R9 waits for request");
    periph_req = 1'b1;
    wait_done();
    periph_req = 1'b0;
    chk("R9 paced copy", mem[32'h7804], pat(32'h7004));
    wr(6'h04, 0); wr(6'h00, 0);
    wr(6'h18, 32'h7100); wr(6'h2C, 32'h7900); wr(6'h10, 4);
    wr(6'h00, EN | W32 | 32'h4000 | 32'h100_0000);
    wait_done();
    chk("R9 free running", mem[32'h7900], pat(32'h7100));
    wr(6'h04, 0); wr(6'h00, 0);

    tag = "R10";
    bwc_seen = 0;
    wr(6'h18, 32'h8000); wr(6'h2C, 32'h8800); wr(6'h10, 12);
    wr(6'h00, EN | W32 | (32'd3 << 25)); wr(6'h00, GO | W32 | (32'd3 << 25));
    wait_done();
    chk("R10 wait cycles", 32'(bwc_seen), 32'd9);
    wr(6'h04, 0); wr(6'h00, 0);

    tag = "R3";
    wr(6'h18, 32'h9000); wr(6'h2C, 32'h9800); wr(6'h10, 200);
    wr(6'h00, EN | W32); wr(6'h00, GO | W32);
    repeat (7) @(negedge clk);
    wr(6'h00, 0);
    chk("R3 abort drops req", {31'd0, mem_req}, 0);
    @(negedge clk); chk("R3 abort idle", {29'd0, rd_data[3:1]}, 0);
    wr(6'h10, 0);

    tag = "R12";
    wr(6'h00, 32'hFEE0_7E14); rd(6'h00, d); chk("R12 ctrl readback", d, 32'hFEE0_7E04);
    wr(6'h00, 0);
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: act %0d cycles exp finish", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule